// File: doc/BRIEF.md
# SPI Master Byte Transfer Engine

This block is the shifting and sequencing core of an SPI master. A single 32-bit control word sets the clock polarity and phase, the bit order, which of four chip-select lines is used and how it behaves, and whether received bytes are kept. Writing the control word with its start bit set launches a transfer whose length and transmit portion come from two byte counts sampled at that moment.

Transmit bytes are pulled from an external TX FIFO through a pop/empty/data interface. Once the transmit count is used up, the engine keeps clocking zero bytes until the burst count is reached. Each received byte is pushed to an external RX FIFO. The serial clock rate is set outside the block: every `sclk_tick` pulse advances the serial clock by one half period. When the last byte has been exchanged, the engine pulses `xfer_done` and clears the start bit.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset the control readback is zero, `xfer_done` is low and every chip-select line is inactive. While no transfer runs, `sclk` equals control bit 1 (clock polarity). Control bits other than 31, 12, 8, 7..4 and 2..0 always read as zero.
- R2: Writing the control word with bit 31 set while idle starts a transfer. Bit 31 reads as 1 while the transfer runs and clears one cycle after `xfer_done`, which is a single-cycle pulse.
- R3: Control writes made while bit 31 is set are ignored, and the readback keeps its previous value.
- R4: With control bit 0 (clock phase) clear, MOSI is stable on the leading `sclk` edge (the edge leaving the idle level) and MISO is sampled there. With bit 0 set, MOSI changes on the leading edge and MISO is sampled on the trailing edge. Each byte takes 16 `sclk` edges, and `sclk` changes only in the cycle after a tick.
- R5: Control bit 12 set shifts each byte least-significant bit first. Bit 12 clear shifts most-significant bit first. The same order applies in both directions.
- R6: A transfer exchanges exactly `burst_len` bytes. A burst count of zero gives a `xfer_done` pulse with no `sclk` edge and no FIFO access.
- R7: The first `tx_len` bytes of a burst are popped from the TX FIFO, one pop per byte. The remaining bytes of the burst are sent as 0x00 with no pop.
- R8: If the TX FIFO is empty while transmit bytes remain, `sclk` holds its idle level and no pop occurs until data arrives. A pop never happens while the FIFO is empty.
- R9: Each exchanged byte is pushed to the RX FIFO once, unless control bit 8 is set. With bit 8 set, no push occurs.
- R10: Control bits 5:4 select one chip-select line. Bit 2 set makes the active level low, and bit 2 clear makes it high. Without manual control, the selected line is active only while bit 31 is set, and all other lines are always inactive.
- R11: With control bit 6 set, the selected line follows control bit 7 whether or not a transfer runs, and all other lines stay inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word readback |
| burst_len | input | 24 | Total bytes of the transfer, sampled at start |
| tx_len | input | 24 | Bytes taken from the TX FIFO, sampled at start |
| sclk_tick | input | 1 | Half-period advance of the serial clock |
| txq_empty | input | 1 | TX FIFO empty |
| txq_data | input | 8 | TX FIFO head byte |
| txq_pop | output | 1 | TX FIFO pop |
| rxq_push | output | 1 | RX FIFO push |
| rxq_data | output | 8 | Received byte |
| xfer_done | output | 1 | Transfer-complete pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |

## Verification
On every cycle, the assertions check that the serial clock moves only after a tick and sits at its idle level outside a transfer. They also check that pops never hit an empty FIFO, that the configuration stays frozen while a transfer runs, that a new byte is loaded only into an idle shifter, and that the completion pulse clears the start bit. The bench scenarios are needed for the rest: the bit order seen on the wire in all four clock modes, the zero fill after the transmit count, the stall on an empty FIFO, the discard of receive data, the zero-length burst, and the automatic and manual chip-select levels. A slave model in the bench samples MOSI on the edges the phase setting calls for and feeds back inverted data. The scoreboard compares both directions against the expected byte queues.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  // Control word field positions
  localparam int CW_CPHA  = 0;
  localparam int CW_CPOL  = 1;
  localparam int CW_CSLOW = 2;
  localparam int CW_SEL   = 4;
  localparam int CW_MAN   = 6;
  localparam int CW_LVL   = 7;
  localparam int CW_DROP  = 8;
  localparam int CW_LSB   = 12;
  localparam int CW_GO    = 31;

  localparam logic [31:0] CW_MASK = 32'h8000_11F7;

  typedef struct packed {
    logic       go;
    logic       lsb;
    logic       drop;
    logic       lvl;
    logic       man;
    logic [1:0] sel;
    logic       cs_low;
    logic       cpol;
    logic       cpha;
  } xfer_cfg_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FETCH = 2'd1,
    SQ_RUN   = 2'd2
  } seq_state_e;

  function automatic xfer_cfg_t unpack_cfg(input logic [31:0] w);
    xfer_cfg_t c;
    c.go     = w[CW_GO];
    c.lsb    = w[CW_LSB];
    c.drop   = w[CW_DROP];
    c.lvl    = w[CW_LVL];
    c.man    = w[CW_MAN];
    c.sel    = w[CW_SEL+1:CW_SEL];
    c.cs_low = w[CW_CSLOW];
    c.cpol   = w[CW_CPOL];
    c.cpha   = w[CW_CPHA];
    return c;
  endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              tick,
  input  logic              cpha,
  input  logic              lsb,
  input  logic              miso,
  output logic              mosi,
  output logic              clk_lvl,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte
);

  localparam int CNT_W = $clog2(2 * DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(2 * DATA_W - 1);

  logic              active_q, active_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              lvl_q, lvl_d;
  logic [DATA_W-1:0] tsr_q, tsr_d;
  logic [DATA_W-1:0] rsr_q, rsr_d;
  logic [DATA_W-1:0] rxb_q, rxb_d;
  logic              bdone_q, bdone_d;

  logic              leading, sample_now, shift_now;
  logic [DATA_W-1:0] rx_in, tx_sh;

  always_comb begin
    leading    = ~cnt_q[0];
    sample_now = cpha ? ~leading : leading;
    shift_now  = cpha ? (leading && (cnt_q != '0)) : (~leading && (cnt_q != LAST));
    rx_in      = lsb ? {miso, rsr_q[DATA_W-1:1]} : {rsr_q[DATA_W-2:0], miso};
    tx_sh      = lsb ? {1'b0, tsr_q[DATA_W-1:1]} : {tsr_q[DATA_W-2:0], 1'b0};
  end

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    lvl_d    = lvl_q;
    tsr_d    = tsr_q;
    rsr_d    = rsr_q;
    rxb_d    = rxb_q;
    bdone_d  = 1'b0;
    if (load) begin
      active_d = 1'b1;
      cnt_d    = '0;
      lvl_d    = 1'b0;
      tsr_d    = load_byte;
    end else if (active_q && tick) begin
      lvl_d = ~lvl_q;
      cnt_d = cnt_q + CNT_W'(1);
      if (sample_now) rsr_d = rx_in;
      if (shift_now)  tsr_d = tx_sh;
      if (cnt_q == LAST) begin
        active_d = 1'b0;
        bdone_d  = 1'b1;
        rxb_d    = sample_now ? rx_in : rsr_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      lvl_q    <= 1'b0;
      tsr_q    <= '0;
      rsr_q    <= '0;
      rxb_q    <= '0;
      bdone_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      lvl_q    <= lvl_d;
      tsr_q    <= tsr_d;
      rsr_q    <= rsr_d;
      rxb_q    <= rxb_d;
      bdone_q  <= bdone_d;
    end
  end

  assign mosi      = lsb ? tsr_q[0] : tsr_q[DATA_W-1];
  assign clk_lvl   = lvl_q;
  assign byte_done = bdone_q;
  assign rx_byte   = rxb_q;

  // R4: the serial clock level moves only in the cycle after a tick
  p_edge_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> $past(tick));

  // R6: a new byte is never loaded over one still being shifted
  p_load_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active_q);

endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_eng_pkg::*;
#(
  parameter int LEN_W  = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic              txq_empty,
  input  logic [DATA_W-1:0] txq_data,
  output logic              txq_pop,
  input  logic              byte_done,
  output logic              load,
  output logic [DATA_W-1:0] load_byte,
  output logic              done
);

  seq_state_e       state_q, state_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [LEN_W-1:0] txl_q, txl_d;
  logic             done_q, done_d;

  always_comb begin
    state_d   = state_q;
    left_d    = left_q;
    txl_d     = txl_q;
    done_d    = 1'b0;
    load      = 1'b0;
    load_byte = '0;
    txq_pop   = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start) begin
          if (burst_len == '0) begin
            done_d = 1'b1;
          end else begin
            left_d  = burst_len;
            txl_d   = tx_len;
            state_d = SQ_FETCH;
          end
        end
      end
      SQ_FETCH: begin
        if (txl_q != '0) begin
          if (!txq_empty) begin
            load      = 1'b1;
            load_byte = txq_data;
            txq_pop   = 1'b1;
            txl_d     = txl_q - LEN_W'(1);
            state_d   = SQ_RUN;
          end
        end else begin
          load    = 1'b1;
          state_d = SQ_RUN;
        end
      end
      SQ_RUN: begin
        if (byte_done) begin
          left_d = left_q - LEN_W'(1);
          if (left_q == LEN_W'(1)) begin
            done_d  = 1'b1;
            state_d = SQ_IDLE;
          end else begin
            state_d = SQ_FETCH;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      left_q  <= '0;
      txl_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      txl_q   <= txl_d;
      done_q  <= done_d;
    end
  end

  assign done = done_q;

  // R8: the TX FIFO is never popped while it reports empty
  p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    txq_pop |-> !txq_empty);

endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
  parameter int NUM_CS = 4,
  parameter int SEL_W  = $clog2(NUM_CS)
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic              man,
  input  logic              lvl,
  input  logic              cs_low,
  input  logic              busy,
  output logic [NUM_CS-1:0] cs_o
);

  logic idle_lvl, act_lvl;

  assign idle_lvl = cs_low;
  assign act_lvl  = ~cs_low;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    assign cs_o[i] = (sel == SEL_W'(i)) ?
                     (man ? lvl : (busy ? act_lvl : idle_lvl)) : idle_lvl;
  end

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int LEN_W  = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [31:0]       ctl_wdata,
  output logic [31:0]       ctl_rdata,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic              sclk_tick,
  input  logic              txq_empty,
  input  logic [DATA_W-1:0] txq_data,
  output logic              txq_pop,
  output logic              rxq_push,
  output logic [DATA_W-1:0] rxq_data,
  output logic              xfer_done,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [3:0]        cs_o
);

  localparam int NUM_CS = 4;

  logic [31:0]       ctl_q, ctl_d;
  xfer_cfg_t         cfg;
  logic              busy, wr_ok, start, done;
  logic              load, byte_done, clk_lvl;
  logic [DATA_W-1:0] load_byte, rx_byte;

  assign cfg   = unpack_cfg(ctl_q);
  assign busy  = cfg.go;
  assign wr_ok = ctl_we & ~busy;
  assign start = wr_ok & ctl_wdata[CW_GO];

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ok)     ctl_d = ctl_wdata & CW_MASK;
    else if (done) ctl_d[CW_GO] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  spi_xfer_seq #(.LEN_W(LEN_W), .DATA_W(DATA_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .burst_len (burst_len),
    .tx_len    (tx_len),
    .txq_empty (txq_empty),
    .txq_data  (txq_data),
    .txq_pop   (txq_pop),
    .byte_done (byte_done),
    .load      (load),
    .load_byte (load_byte),
    .done      (done)
  );

  spi_byte_shifter #(.DATA_W(DATA_W)) i_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_byte (load_byte),
    .tick      (sclk_tick),
    .cpha      (cfg.cpha),
    .lsb       (cfg.lsb),
    .miso      (miso),
    .mosi      (mosi),
    .clk_lvl   (clk_lvl),
    .byte_done (byte_done),
    .rx_byte   (rx_byte)
  );

  spi_cs_drive #(.NUM_CS(NUM_CS)) i_cs (
    .sel    (cfg.sel),
    .man    (cfg.man),
    .lvl    (cfg.lvl),
    .cs_low (cfg.cs_low),
    .busy   (busy),
    .cs_o   (cs_o)
  );

  assign ctl_rdata = ctl_q;
  assign sclk      = cfg.cpol ^ clk_lvl;
  assign rxq_push  = byte_done & ~cfg.drop;
  assign rxq_data  = rx_byte;
  assign xfer_done = done;

  // R1: outside a transfer the serial clock rests at the polarity level
  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[CW_GO] |-> sclk == ctl_q[CW_CPOL]);

  // R2: the completion pulse is followed by a cleared start bit
  p_go_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !ctl_q[CW_GO]);

  // R3: configuration bits stay frozen while a transfer runs
  p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[CW_GO] |=> $stable(ctl_q[30:0]));

endmodule

// File: tb/test_spi_xfer_engine.sv
module test_spi_xfer_engine;

  logic        clk;
  logic        rst_n;
  logic        ctl_we;
  logic [31:0] ctl_wdata;
  logic [31:0] ctl_rdata;
  logic [23:0] burst_len;
  logic [23:0] tx_len;
  logic        sclk_tick;
  logic        txq_empty;
  logic [7:0]  txq_data;
  logic        txq_pop;
  logic        rxq_push;
  logic [7:0]  rxq_data;
  logic        xfer_done;
  logic        sclk;
  logic        mosi;
  logic        miso;
  logic [3:0]  cs_o;

  int n_checks = 0;
  int n_err = 0;

  spi_xfer_engine i_spi_xfer_engine (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .burst_len(burst_len), .tx_len(tx_len),
    .sclk_tick(sclk_tick), .txq_empty(txq_empty), .txq_data(txq_data),
    .txq_pop(txq_pop), .rxq_push(rxq_push), .rxq_data(rxq_data),
    .xfer_done(xfer_done), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_o(cs_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Slave returns the inverse of what it hears
  assign miso = ~mosi;

  // Tick every third cycle
  int tdiv = 0;
  always @(negedge clk) tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
  assign sclk_tick = (tdiv == 0);

  // TX FIFO model
  logic [7:0] fmem [0:63];
  int wptr = 0;
  int rptr = 0;
  int pop_cnt = 0;
  assign txq_empty = (wptr == rptr);
  assign txq_data  = fmem[rptr % 64];
  always @(posedge clk) if (txq_pop) begin
    rptr <= rptr + 1;
    pop_cnt <= pop_cnt + 1;
  end

  // Scoreboard
  logic [7:0] exp_wire[$];
  logic [7:0] exp_rx[$];
  bit exp_cpol, exp_cpha, exp_lsb, exp_drop;
  int done_cnt = 0;
  int push_cnt = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  // Monitor: wire sampling, receive compare, done counting
  logic       prev_sclk = 1'b0;
  logic       prev_busy = 1'b0;
  logic [7:0] wbyte = 8'h00;
  int         wbits = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_busy && ctl_rdata[31] && sclk != prev_sclk) begin
        bit leading, samp;
        check(sclk_tick, "R4 sclk edge after tick", 32'(sclk_tick), 32'd1);
        leading = (prev_sclk == exp_cpol);
        samp = exp_cpha ? !leading : leading;
        if (samp) begin
          wbyte = exp_lsb ? {mosi, wbyte[7:1]} : {wbyte[6:0], mosi};
          wbits++;
          if (wbits == 8) begin
            wbits = 0;
            if (exp_wire.size() == 0)
              check(1'b0, "R6 unexpected wire byte", 32'(wbyte), 32'h0);
            else begin
              logic [7:0] e;
              e = exp_wire.pop_front();
              check(wbyte == e, "R4/R5/R7 wire byte", 32'(wbyte), 32'(e));
            end
          end
        end
      end
      if (rxq_push) begin
        push_cnt++;
        if (exp_rx.size() == 0)
          check(1'b0, "R9 unexpected rx push", 32'(rxq_data), 32'h0);
        else begin
          logic [7:0] e;
          e = exp_rx.pop_front();
          check(rxq_data == e, "R9/R5 rx byte", 32'(rxq_data), 32'(e));
        end
      end
      if (xfer_done) done_cnt++;
    end
    prev_sclk = sclk;
    prev_busy = ctl_rdata[31];
  end

  // Driver tasks
  task automatic push_tx(input logic [7:0] b);
    fmem[wptr % 64] = b;
    wptr++;
    exp_wire.push_back(b);
    if (!exp_drop) exp_rx.push_back(~b);
  endtask

  task automatic expect_zero();
    exp_wire.push_back(8'h00);
    if (!exp_drop) exp_rx.push_back(8'hFF);
  endtask

  task automatic set_mode(input logic [31:0] cw);
    exp_cpha = cw[0];
    exp_cpol = cw[1];
    exp_drop = cw[8];
    exp_lsb  = cw[12];
  endtask

  task automatic start_xfer(input logic [31:0] cw, input int burst, input int txn);
    @(negedge clk);
    burst_len = 24'(burst);
    tx_len    = 24'(txn);
    ctl_wdata = cw | 32'h8000_0000;
    ctl_we    = 1'b1;
    @(negedge clk);
    ctl_we    = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (xfer_done) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
    check(seen, {"R2/R6 done pulse ", tag}, 32'(seen), 32'd1);
    @(negedge clk);
    check(xfer_done == 1'b0, "R2 done is one cycle", 32'(xfer_done), 32'd0);
    check(ctl_rdata[31] == 1'b0, "R2 start bit self-clears", ctl_rdata, 32'h0);
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_sim();
  end

  initial begin
    int pops0;
    int push0;
    rst_n = 1'b0;
    ctl_we = 1'b0;
    ctl_wdata = '0;
    burst_len = '0;
    tx_len = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(ctl_rdata == 32'h0, "R1 readback after reset", ctl_rdata, 32'h0);
    check(cs_o == 4'b0000, "R1 cs inactive after reset", 32'(cs_o), 32'h0);
    check(sclk == 1'b0, "R1 sclk idle after reset", 32'(sclk), 32'h0);
    check(xfer_done == 1'b0, "R1 done low after reset", 32'(xfer_done), 32'h0);

    // R1: unimplemented bits read zero
    @(negedge clk);
    ctl_wdata = 32'h7FFF_FFFF;
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
    check(ctl_rdata == 32'h0000_11F7, "R1 masked readback", ctl_rdata, 32'h0000_11F7);
    check(sclk == 1'b1, "R1 sclk follows polarity", 32'(sclk), 32'h1);

    // T1: mode 0, MSB first, line 0, active low
    set_mode(32'h0000_0004);
    push_tx(8'hA5);
    push_tx(8'h3C);
    start_xfer(32'h0000_0004, 2, 2);
    check(ctl_rdata[31] == 1'b1, "R2 start bit reads 1 while running", ctl_rdata, 32'h8000_0004);
    check(cs_o == 4'b1110, "R10 auto cs active low line 0", 32'(cs_o), 32'he);
    wait_done("T1");
    check(cs_o == 4'b1111, "R10 auto cs released", 32'(cs_o), 32'hf);

    // T2: mode 3, LSB first, line 1, active high
    set_mode(32'h0000_1013);
    push_tx(8'h81);
    push_tx(8'h4E);
    start_xfer(32'h0000_1013, 2, 2);
    check(cs_o == 4'b0010, "R10 auto cs active high line 1", 32'(cs_o), 32'h2);
    wait_done("T2");
    check(sclk == 1'b1, "R1 sclk idle high after mode 3", 32'(sclk), 32'h1);

    // T3: mode 1, zero fill after transmit count
    set_mode(32'h0000_0001);
    pops0 = pop_cnt;
    push_tx(8'hC7);
    expect_zero();
    expect_zero();
    start_xfer(32'h0000_0001, 3, 1);
    wait_done("T3");
    check(pop_cnt - pops0 == 1, "R7 one pop for tx count", 32'(pop_cnt - pops0), 32'd1);

    // T4: mode 2, discard received bytes, line 3
    set_mode(32'h0000_0132);
    push0 = push_cnt;
    push_tx(8'h12);
    push_tx(8'h34);
    start_xfer(32'h0000_0132, 2, 2);
    wait_done("T4");
    check(push_cnt == push0, "R9 no push with discard", 32'(push_cnt - push0), 32'd0);

    // T5: zero-length burst
    set_mode(32'h0000_0000);
    pops0 = pop_cnt;
    start_xfer(32'h0000_0000, 0, 0);
    wait_done("T5");
    check(pop_cnt == pops0, "R6 zero burst no pop", 32'(pop_cnt - pops0), 32'd0);

    // T6: stall on empty FIFO, writes ignored while busy
    set_mode(32'h0000_0020);
    pops0 = pop_cnt;
    start_xfer(32'h0000_0020, 2, 2);
    repeat (30) @(negedge clk);
    check(sclk == 1'b0, "R8 sclk idle while starved", 32'(sclk), 32'h0);
    check(pop_cnt == pops0, "R8 no pop while empty", 32'(pop_cnt - pops0), 32'd0);
    check(cs_o == 4'b0100, "R10 cs held during stall", 32'(cs_o), 32'h4);
    ctl_wdata = 32'h0000_1002;
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
    @(negedge clk);
    check(ctl_rdata == 32'h8000_0020, "R3 write ignored while busy", ctl_rdata, 32'h8000_0020);
    push_tx(8'h5A);
    push_tx(8'hF0);
    wait_done("T6");

    // T7: manual chip select
    @(negedge clk);
    ctl_wdata = 32'h0000_00E0;
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
    check(cs_o == 4'b0100, "R11 manual level 1 on line 2", 32'(cs_o), 32'h4);
    ctl_wdata = 32'h0000_0064;
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
    check(cs_o == 4'b1011, "R11 manual level 0 on line 2", 32'(cs_o), 32'hb);

    repeat (5) @(negedge clk);
    check(exp_wire.size() == 0, "R6 all wire bytes seen", 32'(exp_wire.size()), 32'd0);
    check(exp_rx.size() == 0, "R9 all rx bytes seen", 32'(exp_rx.size()), 32'd0);
    check(done_cnt == 6, "R2 done count", 32'(done_cnt), 32'd6);
    finish_sim();
  end

endmodule